// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns characters into frames on an asynchronous serial line. A character is written into a one-entry holding register. From there it moves into a separate shift stage. The shift stage sends the frame one bit per pulse of an externally generated bit tick. While one frame is on the wire, the next character can already wait in the holding register. It then follows the previous frame with no idle gap.

The frame format is set by static configuration inputs:

- a character length of 5 to 9 bits;
- no parity, even parity or odd parity;
- one or two stop bits.

A ninth data bit is staged through its own strobe before the low byte is written. Two status outputs are provided:

- a buffer-empty flag, which tells the writer that another character may be written;
- a sticky transmit-complete flag, which reports that the line has drained. Writing a one to it clears it.

Dropping the enable blocks new writes. Anything already accepted is still sent.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After synchronous reset, `txd` is 1, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits at 1. Each bit appears on `txd` at one `tick` and stays until the next `tick`. `txd` is 1 whenever no frame is in progress.
- R3: `size_code` selects the data bit count: 000=5, 001=6, 010=7, 011=8, 111=9. Codes 100, 101 and 110 select 8. Stored bits above the selected count are not sent.
- R4: `par_mode` 10 appends even parity, which is the XOR of the sent data bits. `par_mode` 11 appends odd parity, which is the inverse of that XOR. `par_mode` 00 and 01 append no parity bit.
- R5: `two_stop`=1 sends two stop bits. `two_stop`=0 sends one.
- R6: A `wr_hi` pulse stores `wr_bit8` as the ninth data bit. The next accepted `wr_lo` stores that bit together with `wr_data`.
- R7: `buf_empty` falls in the cycle after an accepted `wr_lo`. It rises again in the cycle after the shift stage takes the character.
- R8: A `wr_lo` while `buf_empty` is 0 is ignored. The character already waiting is the one that gets sent.
- R9: If a character is waiting when the last stop bit of a frame ends, its start bit appears on that same `tick`, and `tx_done` stays 0.
- R10: `tx_done` rises at the `tick` that ends a frame when no character is waiting. It then holds until a cycle with `clr_done`=1. If the set and the clear fall in the same cycle, the set wins.
- R11: While `tx_en` is 0, `wr_lo` is ignored. Clearing `tx_en` still lets the frame in flight and the waiting character finish. After that, `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle bit-period pulse from the baud generator |
| tx_en | input | 1 | Transmitter enable; gates acceptance of new characters |
| size_code | input | 3 | Character length code |
| par_mode | input | 2 | Parity mode code |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_lo | input | 1 | Write strobe for the low byte; starts a transfer |
| wr_data | input | 8 | Low eight data bits |
| wr_hi | input | 1 | Write strobe for the staged ninth bit |
| wr_bit8 | input | 1 | Ninth data bit value |
| clr_done | input | 1 | Write-one-to-clear for `tx_done` |
| txd | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding register has no waiting character |
| tx_done | output | 1 | Sticky transmit-complete flag |

## Verification
Two things can land on the same clock edge: the `tick` that ends a frame's final stop bit sets `tx_done`, and a software clear of that flag arrives. The bench drives every `tick` by hand. It can therefore raise `clr_done` in exactly the cycle of the closing `tick`. It then expects `tx_done` to read 1 afterwards, and to read 0 only after a later clear on its own. A second case puts the same closing `tick` together with a waiting character. That start bit must follow at once, and the flag must stay low.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_DATA  = BYTE_W + 1;
  localparam int MAX_FRAME = 1 + MAX_DATA + 1 + 2;
  localparam int CNT_W     = $clog2(MAX_FRAME + 1);

  typedef logic [MAX_DATA-1:0]  word_t;
  typedef logic [MAX_FRAME-1:0] frame_t;
  typedef logic [CNT_W-1:0]     cnt_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSVD = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_e;

  // character length decode; unused codes fall back to eight bits
  function automatic cnt_t data_bits(input logic [2:0] code);
    case (code)
      3'b000:  data_bits = cnt_t'(5);
      3'b001:  data_bits = cnt_t'(6);
      3'b010:  data_bits = cnt_t'(7);
      3'b111:  data_bits = cnt_t'(9);
      default: data_bits = cnt_t'(8);
    endcase
  endfunction
endpackage

// File: rtl/dbtx_hold.sv
module dbtx_hold
  import dbtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_hi,
  input  logic              wr_bit8,
  input  logic              take,
  output logic              full,
  output word_t             word
);
  logic stage8;
  logic accept;

  assign accept = wr_lo && en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage8 <= 1'b0;
    end else if (wr_hi) begin
      stage8 <= wr_bit8;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else if (accept) begin
      full <= 1'b1;
      word <= {stage8, wr_data};
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/dbtx_framer.sv
module dbtx_framer
  import dbtx_pkg::*;
(
  input  word_t       word,
  input  logic [2:0]  size_code,
  input  logic [1:0]  par_mode,
  input  logic        two_stop,
  output frame_t      frame,
  output cnt_t        flen
);
  cnt_t  nbits;
  logic  par_on;
  logic  par_bit;
  word_t masked;

  always_comb begin
    nbits  = data_bits(size_code);
    par_on = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    masked = '0;
    for (int unsigned i = 0; i < MAX_DATA; i++) begin
      if (cnt_t'(i) < nbits) masked[i] = word[i];
    end
    par_bit = (^masked) ^ (par_mode == PAR_ODD);

    frame    = '1;
    frame[0] = 1'b0;
    for (int unsigned i = 0; i < MAX_DATA; i++) begin
      if (cnt_t'(i) < nbits) frame[i+1] = word[i];
    end
    if (par_on) frame[nbits + cnt_t'(1)] = par_bit;

    flen = cnt_t'(2) + nbits + cnt_t'(par_on) + cnt_t'(two_stop);
  end
endmodule

// File: rtl/dbtx_shift.sv
module dbtx_shift
  import dbtx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   hold_full,
  input  frame_t frame,
  input  cnt_t   flen,
  output logic   take,
  output logic   done_set,
  output logic   busy,
  output logic   txd
);
  frame_t sr;
  cnt_t   cnt;
  logic   at_end;

  assign at_end   = busy && tick && (cnt == '0);
  assign take     = hold_full && (!busy || at_end);
  assign done_set = at_end && !hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      sr   <= '1;
      txd  <= 1'b1;
    end else if (!busy) begin
      if (hold_full) begin
        sr   <= frame;
        cnt  <= flen;
        busy <= 1'b1;
      end
    end else if (tick) begin
      if (cnt != '0) begin
        txd <= sr[0];
        sr  <= {1'b1, sr[MAX_FRAME-1:1]};
        cnt <= cnt - cnt_t'(1);
      end else if (hold_full) begin
        txd <= frame[0];
        sr  <= {1'b1, frame[MAX_FRAME-1:1]};
        cnt <= flen - cnt_t'(1);
      end else begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_en,
  input  logic [2:0]        size_code,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_hi,
  input  logic              wr_bit8,
  input  logic              clr_done,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done
);
  logic   hold_full;
  word_t  hold_word;
  frame_t frame_w;
  cnt_t   flen_w;
  logic   take_w;
  logic   done_set_w;
  logic   shf_busy;

  dbtx_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .en      (tx_en),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .wr_hi   (wr_hi),
    .wr_bit8 (wr_bit8),
    .take    (take_w),
    .full    (hold_full),
    .word    (hold_word)
  );

  dbtx_framer u_framer (
    .word      (hold_word),
    .size_code (size_code),
    .par_mode  (par_mode),
    .two_stop  (two_stop),
    .frame     (frame_w),
    .flen      (flen_w)
  );

  dbtx_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .hold_full (hold_full),
    .frame     (frame_w),
    .flen      (flen_w),
    .take      (take_w),
    .done_set  (done_set_w),
    .busy      (shf_busy),
    .txd       (txd)
  );

  assign buf_empty = !hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done <= 1'b0;
    end else if (done_set_w) begin
      tx_done <= 1'b1;
    end else if (clr_done) begin
      tx_done <= 1'b0;
    end
  end
endmodule

// File: rtl/dbtx_checker.sv
module dbtx_checker
  import dbtx_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  tick,
  input logic  tx_en,
  input logic  wr_lo,
  input logic  clr_done,
  input logic  txd,
  input logic  buf_empty,
  input logic  tx_done,
  input logic  busy,
  input logic  take,
  input word_t hold_word
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R2

  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd)); // R2

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    (buf_empty && wr_lo && tx_en) |=> !buf_empty); // R7

  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!buf_empty && !take) |=> (!buf_empty && $stable(hold_word))); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !clr_done) |=> tx_done); // R10

  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && buf_empty) |=> buf_empty); // R11
endmodule

bind dbuf_serial_tx dbtx_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .tx_en     (tx_en),
  .wr_lo     (wr_lo),
  .clr_done  (clr_done),
  .txd       (txd),
  .buf_empty (buf_empty),
  .tx_done   (tx_done),
  .busy      (shf_busy),
  .take      (take_w),
  .hold_word (hold_word)
);

// File: tb/sim_dbuf_serial_tx.sv
module sim_dbuf_serial_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       tx_en = 1'b1;
  logic [2:0] size_code = 3'b011;
  logic [1:0] par_mode = 2'b00;
  logic       two_stop = 1'b0;
  logic       wr_lo = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_hi = 1'b0;
  logic       wr_bit8 = 1'b0;
  logic       clr_done = 1'b0;
  logic       txd;
  logic       buf_empty;
  logic       tx_done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dbuf_serial_tx u0 (
    .clk(clk), .rst(rst), .tick(tick), .tx_en(tx_en),
    .size_code(size_code), .par_mode(par_mode), .two_stop(two_stop),
    .wr_lo(wr_lo), .wr_data(wr_data), .wr_hi(wr_hi), .wr_bit8(wr_bit8),
    .clr_done(clr_done), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  // {size_code, par_mode, two_stop, data[8:0]}
  localparam logic [14:0] VEC [0:7] = '{
    {3'b000, 2'b00, 1'b0, 9'h015},
    {3'b001, 2'b10, 1'b0, 9'h02B},
    {3'b010, 2'b11, 1'b1, 9'h05A},
    {3'b011, 2'b10, 1'b1, 9'h0A7},
    {3'b111, 2'b11, 1'b0, 9'h13C},
    {3'b111, 2'b00, 1'b1, 9'h0FF},
    {3'b101, 2'b01, 1'b0, 9'h0C3},
    {3'b000, 2'b11, 1'b1, 9'h1FF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] sc, input logic [1:0] pm,
                                input logic ts, input logic [8:0] d,
                                output logic [12:0] f, output int len);
    int  n;
    logic p;
    n = (sc == 3'b000) ? 5 : (sc == 3'b001) ? 6 : (sc == 3'b010) ? 7 :
        (sc == 3'b111) ? 9 : 8;
    f = '1;
    f[0] = 1'b0;
    len = 1;
    p = pm[0];
    for (int i = 0; i < n; i++) begin
      f[len] = d[i];
      p = p ^ d[i];
      len++;
    end
    if (pm[1]) begin
      f[len] = p;
      len++;
    end
    len = len + (ts ? 2 : 1);
  endfunction

  task automatic write_hi(input logic b);
    @(negedge clk); wr_hi = 1'b1; wr_bit8 = b;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic write_lo(input logic [7:0] d);
    @(negedge clk); wr_lo = 1'b1; wr_data = d;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic pulse(input logic clr);
    @(negedge clk); tick = 1'b1; clr_done = clr;
    @(negedge clk); tick = 1'b0; clr_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_done();
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
  endtask

  task automatic collect(input int from, input int len, inout logic [12:0] got);
    for (int i = from; i < len; i++) begin
      pulse(1'b0);
      got[i] = txd;
    end
  endtask

  task automatic run_vec(input int k);
    logic [12:0] f;
    logic [12:0] got;
    int          len;
    string       tag;
    tag = $sformatf("R2 R3 R4 R5 R6 vec%0d", k);
    @(negedge clk);
    size_code = VEC[k][14:12];
    par_mode  = VEC[k][11:10];
    two_stop  = VEC[k][9];
    write_hi(VEC[k][8]);
    write_lo(VEC[k][7:0]);
    chk("R7 empty low after write", 32'(buf_empty), 32'd0);
    @(negedge clk);
    chk("R7 empty high after take", 32'(buf_empty), 32'd1);
    model(VEC[k][14:12], VEC[k][11:10], VEC[k][9], VEC[k][8:0], f, len);
    got = '1;
    collect(0, len, got);
    chk(tag, 32'(got), 32'(f));
    pulse(1'b0);
    chk("R10 done after frame", 32'(tx_done), 32'd1);
    chk("R2 line idle high", 32'(txd), 32'd1);
    clear_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] f;
    logic [12:0] got;
    int          len;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd reset", 32'(txd), 32'd1);
    chk("R1 buf_empty reset", 32'(buf_empty), 32'd1);
    chk("R1 tx_done reset", 32'(tx_done), 32'd0);

    for (int k = 0; k < 8; k++) run_vec(k);

    // back-to-back frames, overwrite ignored while full
    size_code = 3'b011; par_mode = 2'b00; two_stop = 1'b0;
    write_hi(1'b0);
    write_lo(8'h96);
    @(negedge clk);
    write_lo(8'h3C);
    chk("R7 empty low with second char", 32'(buf_empty), 32'd0);
    write_lo(8'hE1);
    chk("R8 write while full keeps full", 32'(buf_empty), 32'd0);
    model(3'b011, 2'b00, 1'b0, 9'h096, f, len);
    got = '1;
    collect(0, len, got);
    chk("R2 first frame", 32'(got), 32'(f));
    pulse(1'b0);
    chk("R9 start follows stop at once", 32'(txd), 32'd0);
    chk("R9 no done between frames", 32'(tx_done), 32'd0);
    model(3'b011, 2'b00, 1'b0, 9'h03C, f, len);
    got = '1;
    got[0] = 1'b0;
    collect(1, len, got);
    chk("R8 waiting char kept, not overwritten", 32'(got), 32'(f));
    pulse(1'b0);
    chk("R10 done after pair", 32'(tx_done), 32'd1);
    clear_done();
    chk("R10 done cleared by write-one", 32'(tx_done), 32'd0);

    // completion and clear in the same cycle
    size_code = 3'b000; par_mode = 2'b10; two_stop = 1'b0;
    write_lo(8'h0B);
    @(negedge clk);
    model(3'b000, 2'b10, 1'b0, 9'h00B, f, len);
    got = '1;
    collect(0, len, got);
    chk("R4 even parity short frame", 32'(got), 32'(f));
    pulse(1'b1);
    chk("R10 set wins over clear", 32'(tx_done), 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 done sticky", 32'(tx_done), 32'd1);
    clear_done();
    chk("R10 cleared afterwards", 32'(tx_done), 32'd0);

    // disable drains buffered data, then blocks writes
    size_code = 3'b010; par_mode = 2'b11; two_stop = 1'b1;
    write_lo(8'h55);
    @(negedge clk);
    write_lo(8'h2A);
    tx_en = 1'b0;
    model(3'b010, 2'b11, 1'b1, 9'h055, f, len);
    got = '1;
    collect(0, len, got);
    chk("R11 in-flight frame finishes", 32'(got), 32'(f));
    pulse(1'b0);
    chk("R11 buffered start after disable", 32'(txd), 32'd0);
    model(3'b010, 2'b11, 1'b1, 9'h02A, f, len);
    got = '1;
    got[0] = 1'b0;
    collect(1, len, got);
    chk("R11 buffered frame finishes", 32'(got), 32'(f));
    pulse(1'b0);
    chk("R11 done after drain", 32'(tx_done), 32'd1);
    write_lo(8'h77);
    chk("R11 write ignored when disabled", 32'(buf_empty), 32'd1);
    for (int i = 0; i < 3; i++) begin
      pulse(1'b0);
      chk("R11 line stays high", 32'(txd), 32'd1);
    end
    clear_done();
    tx_en = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule